// File: doc/BRIEF.md
# Three-Level Translation Table Walker

This block resolves a virtual page number into a physical frame when the translation cache misses. It accepts a virtual page number with the root table address of the current address space. It then reads one 8-byte table entry per level from memory, three levels in all. An intermediate entry points to the next table. The last entry supplies the frame number and the protection and usage flags. An entry with its valid flag clear ends the walk early with a fault that names the level. An address outside the implemented range is rejected before any memory traffic.

The request port and the memory read port are valid/ready streams. A request is taken only on a cycle where `req_valid` and `req_ready` are both high, and `req_ready` is high only when the walker is idle. The memory request holds its valid and address until `mem_req_ready` is seen. Only one read is ever outstanding, and `mem_rsp_ready` is raised only while that read is awaited. The result side is a plain one-cycle `done` pulse with the fields beside it and has no back-pressure.

Top module: `tw_walker`

## Requirements
- R1: After reset `req_ready` is 1, while `done` and `mem_req_valid` are 0. `req_ready` is 0 from the cycle after a request is accepted until the cycle after the `done` pulse, so a request offered in that time is ignored.
- R2: The virtual page number is `req_vpn` = VA[63:13]. If VA[63:43] (`req_vpn[50:30]`) is neither all zeros nor all ones, `done` rises one cycle after acceptance with `fault`=1 and `fault_level`=0, and no memory read is issued.
- R3: The first read address is `req_base` + 8 × VA[42:33] (`req_vpn[29:20]`).
- R4: The second read address is (first entry frame × 8192) + 8 × VA[32:23]. The third is (second entry frame × 8192) + 8 × VA[22:13].
- R5: Entry layout: bit 0 valid, bit 1 write enable, bit 2 dirty, bit 3 referenced, bits [58:32] frame number. The other bits are ignored.
- R6: An entry at level n (1, 2 or 3) with bit 0 clear ends the walk. `done` rises with `fault`=1 and `fault_level`=n, and no further read is issued.
- R7: When all three entries are valid, `done` rises with `fault`=0. `res_pfn`, `res_write_en`, `res_dirty` and `res_refd` then carry the third entry's fields.
- R8: While `mem_req_valid` is 1 and `mem_req_ready` is 0, `mem_req_valid` stays 1 and `mem_req_addr` stays unchanged.
- R9: `done` is a single-cycle pulse. It appears in the cycle after the final response is taken, or after a rejected request is accepted.
- R10: At most one read is in flight. `mem_rsp_ready` is 0 while a request is being offered, and a response offered then has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Walk request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | 51 | Virtual address bits 63:13 |
| req_base | input | 40 | Root table physical address |
| mem_req_valid | output | 1 | Entry read request valid |
| mem_req_ready | input | 1 | Memory takes the read request |
| mem_req_addr | output | 40 | Entry physical byte address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker awaits read data |
| mem_rsp_data | input | 64 | Table entry returned |
| done | output | 1 | Result pulse |
| fault | output | 1 | Walk failed |
| fault_level | output | 2 | 0 address range, 1..3 failing level |
| res_pfn | output | 27 | Translated frame number |
| res_write_en | output | 1 | Write permission of the page |
| res_dirty | output | 1 | Dirty flag of the page |
| res_refd | output | 1 | Referenced flag of the page |

## Verification
The bench uses the default parameters: a 64-bit virtual address over 13-bit pages with 10-bit indices, 40-bit physical addresses and 27-bit frames. With these values, index fields of 0 and 1023 reach the lowest and highest entry of a table placed at the top of the physical space. The 21-bit range field can be given single stray bits at either end, and an all-ones field exercises the upper half of the address space. Memory stalls of several cycles and stray responses during a stall test the hold and single-read rules. Missing or cleared entries at each level produce every fault code.

// File: rtl/tw_pkg.sv
package tw_pkg;
  localparam int unsigned NUM_LVL = 3;
  localparam int unsigned FLG_V   = 0;
  localparam int unsigned FLG_WE  = 1;
  localparam int unsigned FLG_D   = 2;
  localparam int unsigned FLG_R   = 3;
  localparam int unsigned FLG_W   = 4;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_ISSUE = 2'd1,
    S_WAIT  = 2'd2
  } tw_state_e;
endpackage

// File: rtl/tw_addr_gen.sv
module tw_addr_gen
  import tw_pkg::*;
#(
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned PA_W      = 40,
  parameter int unsigned ENT_SHIFT = 3
) (
  input  logic [NUM_LVL*IDX_W-1:0] idx_bits,
  input  logic [1:0]               lvl,
  input  logic [PA_W-1:0]          table_base,
  output logic [PA_W-1:0]          entry_addr
);
  localparam int unsigned OFS_W = IDX_W + ENT_SHIFT;

  logic [IDX_W-1:0] idx_arr [NUM_LVL];
  logic [IDX_W-1:0] sel;

  genvar g;
  generate
    for (g = 0; g < NUM_LVL; g++) begin : g_field
      assign idx_arr[g] = idx_bits[(NUM_LVL-1-g)*IDX_W +: IDX_W];
    end
  endgenerate

  always_comb begin
    sel = '0;
    for (int k = 0; k < NUM_LVL; k++) begin
      if (lvl == 2'(k + 1)) sel = idx_arr[k];
    end
  end

  logic [OFS_W-1:0] byte_ofs;
  assign byte_ofs   = {sel, {ENT_SHIFT{1'b0}}};
  assign entry_addr = table_base + PA_W'(byte_ofs);
endmodule

// File: rtl/tw_pte_decode.sv
module tw_pte_decode
  import tw_pkg::*;
#(
  parameter int unsigned PFN_W = 27,
  parameter int unsigned OFF_W = 13
) (
  input  logic [FLG_W-1:0]       flags,
  input  logic [PFN_W-1:0]       pfn_field,
  output logic                   ent_valid,
  output logic                   ent_we,
  output logic                   ent_dirty,
  output logic                   ent_refd,
  output logic [PFN_W-1:0]       ent_pfn,
  output logic [PFN_W+OFF_W-1:0] next_base
);
  assign ent_valid = flags[FLG_V];
  assign ent_we    = flags[FLG_WE];
  assign ent_dirty = flags[FLG_D];
  assign ent_refd  = flags[FLG_R];
  assign ent_pfn   = pfn_field;
  assign next_base = {pfn_field, {OFF_W{1'b0}}};
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_pkg::*;
#(
  parameter int unsigned VPN_W = 51,
  parameter int unsigned IDX_W = 10,
  parameter int unsigned PA_W  = 40,
  parameter int unsigned PFN_W = 27
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [VPN_W-1:0]         req_vpn,
  input  logic [PA_W-1:0]          req_base,
  output logic                     mem_req_valid,
  input  logic                     mem_req_ready,
  input  logic                     mem_rsp_valid,
  output logic                     mem_rsp_ready,
  input  logic                     ent_valid,
  input  logic                     ent_we,
  input  logic                     ent_dirty,
  input  logic                     ent_refd,
  input  logic [PFN_W-1:0]         ent_pfn,
  input  logic [PA_W-1:0]          next_base,
  output logic [1:0]               walk_lvl,
  output logic [PA_W-1:0]          walk_base,
  output logic [NUM_LVL*IDX_W-1:0] walk_idx,
  output logic                     done,
  output logic                     fault,
  output logic [1:0]               fault_level,
  output logic [PFN_W-1:0]         res_pfn,
  output logic                     res_write_en,
  output logic                     res_dirty,
  output logic                     res_refd
);
  localparam int unsigned IDXS_W = NUM_LVL * IDX_W;
  localparam int unsigned SEG_W  = VPN_W - IDXS_W;
  localparam logic [1:0]  LAST   = 2'(NUM_LVL);

  tw_state_e          state_q;
  logic [1:0]         lvl_q;
  logic [PA_W-1:0]    base_q;
  logic [IDXS_W-1:0]  idx_q;
  logic               done_q, fault_q;
  logic [1:0]         flvl_q;
  logic [PFN_W-1:0]   pfn_q;
  logic               we_q, dirty_q, refd_q;

  logic [SEG_W-1:0] seg;
  logic             seg_ok, accept, rsp_take;

  assign seg      = req_vpn[VPN_W-1:IDXS_W];
  assign seg_ok   = (&seg) | ~(|seg);
  assign req_ready     = (state_q == S_IDLE) && !done_q;
  assign accept        = req_valid && req_ready;
  assign mem_req_valid = (state_q == S_ISSUE);
  assign mem_rsp_ready = (state_q == S_WAIT);
  assign rsp_take      = mem_rsp_valid && mem_rsp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lvl_q   <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      flvl_q  <= '0;
      pfn_q   <= '0;
      we_q    <= 1'b0;
      dirty_q <= 1'b0;
      refd_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            idx_q  <= req_vpn[IDXS_W-1:0];
            base_q <= req_base;
            lvl_q  <= 2'd1;
            if (seg_ok) begin
              state_q <= S_ISSUE;
            end else begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              flvl_q  <= 2'd0;
            end
          end
        end
        S_ISSUE: begin
          if (mem_req_ready) state_q <= S_WAIT;
        end
        S_WAIT: begin
          if (rsp_take) begin
            if (!ent_valid) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              flvl_q  <= lvl_q;
              state_q <= S_IDLE;
            end else if (lvl_q == LAST) begin
              done_q  <= 1'b1;
              fault_q <= 1'b0;
              flvl_q  <= 2'd0;
              pfn_q   <= ent_pfn;
              we_q    <= ent_we;
              dirty_q <= ent_dirty;
              refd_q  <= ent_refd;
              state_q <= S_IDLE;
            end else begin
              base_q  <= next_base;
              lvl_q   <= lvl_q + 2'd1;
              state_q <= S_ISSUE;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign walk_lvl     = lvl_q;
  assign walk_base    = base_q;
  assign walk_idx     = idx_q;
  assign done         = done_q;
  assign fault        = fault_q;
  assign fault_level  = flvl_q;
  assign res_pfn      = pfn_q;
  assign res_write_en = we_q;
  assign res_dirty    = dirty_q;
  assign res_refd     = refd_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready); // R1
  AST_SEG_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !seg_ok) |=> (done_q && fault_q && flvl_q == 2'd0 && !mem_req_valid)); // R2
  AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (lvl_q != 2'd0)); // R3
  AST_FAULT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_take && !ent_valid) |=> (done_q && fault_q && flvl_q == $past(lvl_q))); // R6
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(base_q) && $stable(lvl_q))); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R9
  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !mem_rsp_ready); // R10
endmodule

// File: rtl/tw_walker.sv
module tw_walker
  import tw_pkg::*;
#(
  parameter int unsigned VA_W      = 64,
  parameter int unsigned OFF_W     = 13,
  parameter int unsigned IDX_W     = 10,
  parameter int unsigned PA_W      = 40,
  parameter int unsigned PTE_W     = 64,
  parameter int unsigned PFN_LSB   = 32,
  parameter int unsigned ENT_SHIFT = 3,
  localparam int unsigned VPN_W    = VA_W - OFF_W,
  localparam int unsigned PFN_W    = PA_W - OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VPN_W-1:0] req_vpn,
  input  logic [PA_W-1:0]  req_base,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  output logic             mem_rsp_ready,
  input  logic [PTE_W-1:0] mem_rsp_data,
  output logic             done,
  output logic             fault,
  output logic [1:0]       fault_level,
  output logic [PFN_W-1:0] res_pfn,
  output logic             res_write_en,
  output logic             res_dirty,
  output logic             res_refd
);
  localparam int unsigned IDXS_W = NUM_LVL * IDX_W;

  logic [1:0]        walk_lvl;
  logic [PA_W-1:0]   walk_base;
  logic [IDXS_W-1:0] walk_idx;
  logic              ent_valid, ent_we, ent_dirty, ent_refd;
  logic [PFN_W-1:0]  ent_pfn;
  logic [PA_W-1:0]   next_base;
  logic              unused_pte_bits;

  assign unused_pte_bits = ^{mem_rsp_data[PTE_W-1:PFN_LSB+PFN_W],
                             mem_rsp_data[PFN_LSB-1:FLG_W]};

  tw_pte_decode #(.PFN_W(PFN_W), .OFF_W(OFF_W)) u_dec (
    .flags     (mem_rsp_data[FLG_W-1:0]),
    .pfn_field (mem_rsp_data[PFN_LSB +: PFN_W]),
    .ent_valid (ent_valid),
    .ent_we    (ent_we),
    .ent_dirty (ent_dirty),
    .ent_refd  (ent_refd),
    .ent_pfn   (ent_pfn),
    .next_base (next_base)
  );

  tw_addr_gen #(.IDX_W(IDX_W), .PA_W(PA_W), .ENT_SHIFT(ENT_SHIFT)) u_agen (
    .idx_bits   (walk_idx),
    .lvl        (walk_lvl),
    .table_base (walk_base),
    .entry_addr (mem_req_addr)
  );

  tw_ctrl #(.VPN_W(VPN_W), .IDX_W(IDX_W), .PA_W(PA_W), .PFN_W(PFN_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_vpn       (req_vpn),
    .req_base      (req_base),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_rsp_valid (mem_rsp_valid),
    .mem_rsp_ready (mem_rsp_ready),
    .ent_valid     (ent_valid),
    .ent_we        (ent_we),
    .ent_dirty     (ent_dirty),
    .ent_refd      (ent_refd),
    .ent_pfn       (ent_pfn),
    .next_base     (next_base),
    .walk_lvl      (walk_lvl),
    .walk_base     (walk_base),
    .walk_idx      (walk_idx),
    .done          (done),
    .fault         (fault),
    .fault_level   (fault_level),
    .res_pfn       (res_pfn),
    .res_write_en  (res_write_en),
    .res_dirty     (res_dirty),
    .res_refd      (res_refd)
  );
endmodule

// File: tb/sim_tw_walker.sv
module sim_tw_walker;
  typedef struct packed {
    logic        flt;
    logic [1:0]  lvl;
    logic [26:0] pfn;
    logic        we;
    logic        d;
    logic        r;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [50:0] req_vpn = '0;
  logic [39:0] req_base = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [39:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        done, fault;
  logic [1:0]  fault_level;
  logic [26:0] res_pfn;
  logic        res_write_en, res_dirty, res_refd;

  int n_chk = 0;
  int n_fail = 0;
  int g_stall = 0;
  int g_lat = 0;
  bit g_spur = 1'b0;
  bit finished = 1'b0;

  logic [63:0] pmem [logic [39:0]];
  logic [39:0] addr_q [$];
  exp_t        exp_q [$];

  always #2.5 clk = ~clk;

  tw_walker u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_base(req_base),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .mem_rsp_data(mem_rsp_data),
    .done(done), .fault(fault), .fault_level(fault_level),
    .res_pfn(res_pfn), .res_write_en(res_write_en),
    .res_dirty(res_dirty), .res_refd(res_refd)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  function automatic logic [63:0] mkpte(input logic [26:0] pfn, input bit v, input bit we, input bit d, input bit r);
    return {5'b0, pfn, 28'b0, r, d, we, v};
  endfunction

  // memory responder: checks read addresses (R3, R4), holding under stall (R8), stray responses (R10)
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [39:0] a0;
        a0 = mem_req_addr;
        for (int s = 0; s < g_stall; s++) begin
          mem_req_ready = 1'b0;
          if (g_spur) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = '1;
          end
          @(negedge clk);
          check(mem_req_valid && mem_req_addr == a0, "R8 request held", {23'b0, mem_req_valid, mem_req_addr}, {24'h1, a0});
          if (g_spur) check(!mem_rsp_ready, "R10 no response taken while requesting", 64'(mem_rsp_ready), 64'd0);
        end
        mem_rsp_valid = 1'b0;
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (addr_q.size() == 0) begin
          check(1'b0, "R2 unexpected read", 64'(a0), 64'd0);
        end else begin
          logic [39:0] ea;
          ea = addr_q.pop_front();
          check(a0 == ea, "R3 R4 entry address", 64'(a0), 64'(ea));
        end
        for (int l = 0; l < g_lat; l++) @(negedge clk);
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = pmem.exists(a0) ? pmem[a0] : 64'd0;
        @(negedge clk);
        mem_rsp_valid = 1'b0;
      end
    end
  end

  // scoreboard monitor: R2 R5 R6 R7 R9
  initial begin
    logic prev_done;
    prev_done = 1'b0;
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (prev_done) check(1'b0, "R9 done longer than one cycle", 64'd1, 64'd0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 unexpected done", 64'd1, 64'd0);
        end else begin
          exp_t e;
          exp_t a;
          e = exp_q.pop_front();
          a = '{flt: fault, lvl: fault_level, pfn: res_pfn, we: res_write_en, d: res_dirty, r: res_refd};
          if (e.flt) begin
            check(a.flt == 1'b1 && a.lvl == e.lvl, (e.lvl == 2'd0) ? "R2 range fault" : "R6 level fault",
                  64'({a.flt, a.lvl}), 64'({e.flt, e.lvl}));
          end else begin
            check(a == e, "R5 R7 translation result", 64'(a), 64'(e));
          end
        end
      end
      prev_done = rst_n && done;
    end
  end

  task automatic walk(input logic [50:0] vpn, input logic [39:0] base, input int st, input int lt, input bit spur);
    exp_t        e;
    logic [20:0] seg;
    logic [39:0] a;
    bit          stop;
    g_stall = st;
    g_lat   = lt;
    g_spur  = spur;
    e = '0;
    seg = vpn[50:30];
    if (!((&seg) || !(|seg))) begin
      e.flt = 1'b1;
      e.lvl = 2'd0;
    end else begin
      a = base;
      stop = 1'b0;
      for (int l = 1; l <= 3; l++) begin
        if (!stop) begin
          logic [9:0]  idx;
          logic [39:0] ea;
          logic [63:0] ent;
          idx = vpn[30-10*l +: 10];
          ea  = a + {27'b0, idx, 3'b000};
          addr_q.push_back(ea);
          ent = pmem.exists(ea) ? pmem[ea] : 64'd0;
          if (!ent[0]) begin
            e.flt = 1'b1;
            e.lvl = 2'(l);
            stop  = 1'b1;
          end else if (l == 3) begin
            e.pfn = ent[58:32];
            e.we  = ent[1];
            e.d   = ent[2];
            e.r   = ent[3];
          end else begin
            a = {ent[58:32], 13'b0};
          end
        end
      end
    end
    exp_q.push_back(e);
    do @(negedge clk); while (!req_ready);
    req_valid = 1'b1;
    req_vpn   = vpn;
    req_base  = base;
    @(negedge clk);
    check(!req_ready, "R1 busy after accept", 64'(req_ready), 64'd0);
    req_vpn  = ~vpn;
    req_base = ~base;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  localparam logic [39:0] B1 = 40'h01_0000_0000;
  localparam logic [39:0] B2 = 40'hFF_FFFF_E000;

  initial begin
    pmem[B1 + 40'd40]                  = mkpte(27'h100, 1, 0, 0, 0);
    pmem[40'h20_0000 + 40'd56]         = mkpte(27'h200, 1, 0, 0, 0);
    pmem[40'h40_0000 + 40'd72]         = mkpte(27'h5ABCD, 1, 1, 0, 1);
    pmem[40'h40_0000 + 40'd80]         = mkpte(27'h123, 0, 1, 1, 1);
    pmem[B2 + 40'h1FF8]                = mkpte(27'h300, 1, 0, 0, 0);
    pmem[40'h60_0000 + 40'h1FF8]       = mkpte(27'h301, 1, 0, 0, 0);
    pmem[40'h60_2000 + 40'h1FF8]       = mkpte(27'h7FF_FFFF, 1, 0, 1, 0);
    pmem[B2]                           = mkpte(27'h310, 1, 1, 1, 1);
    pmem[40'h62_0000]                  = mkpte(27'h311, 1, 0, 0, 0);
    pmem[40'h62_2000]                  = mkpte(27'h0, 1, 1, 1, 1) | 64'hF000_0000_FFFF_FFF0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !done && !mem_req_valid, "R1 reset state",
          64'({req_ready, done, mem_req_valid}), 64'b100);

    walk({21'h0, 10'd5, 10'd7, 10'd9}, B1, 0, 0, 0);              // R7 basic
    walk({21'h0, 10'd5, 10'd7, 10'd9}, B1, 3, 2, 1);              // R8 R10 stall and stray data
    walk({21'h0, 10'd6, 10'd7, 10'd9}, B1, 1, 0, 0);              // R6 level 1
    walk({21'h0, 10'd5, 10'd8, 10'd9}, B1, 0, 1, 0);              // R6 level 2
    walk({21'h0, 10'd5, 10'd7, 10'd10}, B1, 2, 0, 1);             // R6 level 3
    walk({21'h000001, 10'd5, 10'd7, 10'd9}, B1, 0, 0, 0);         // R2 low stray bit
    walk({21'h100000, 10'd5, 10'd7, 10'd9}, B1, 0, 0, 0);         // R2 high stray bit
    walk({21'h1FFFFF, 10'd1023, 10'd1023, 10'd1023}, B2, 1, 1, 0); // R4 top indices
    walk({21'h0, 10'd0, 10'd0, 10'd0}, B2, 0, 0, 0);              // R5 ignored bits
    walk({21'h1FFFFE, 10'd0, 10'd0, 10'd0}, B2, 0, 0, 0);         // R2 upper half mismatch

    for (int t = 0; t < 200 && (exp_q.size() != 0 || addr_q.size() != 0); t++) @(negedge clk);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0, "R9 all results seen", 64'(exp_q.size()), 64'd0);
    check(addr_q.size() == 0, "R3 all reads seen", 64'(addr_q.size()), 64'd0);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "R9 watchdog expired", 64'd1, 64'd0);
    finish_run();
  end
endmodule